// File: doc/BRIEF.md
# Synchronous Trigger Routing Matrix

This block is a trigger crossbar. Each of its destinations can be connected to any one of a set of sources: the external trigger inputs (front-panel pins, star lines, differential star inputs and shared backplane lines all arrive on one input vector), a software trigger, or a constant low or high level. Every destination has its own route configuration, written through a plain valid/address/data port.

A route can forward its source in one of two ways:

- **Asynchronously:** a combinational pass-through with no clocking.
- **Synchronously:** the source goes through a two-flop synchronizer into an output register. That register loads on the rising or the falling edge of the synchronization clock (`clk`). The load happens on every cycle, or only on the strobes of one of two shared power-of-two dividers.

Any route may invert its output, so active-low triggers can be handled. A destination with no route configured keeps its output enable low, so a shared bidirectional line is driven only while it is routed. The block has no state machine: its sequencing is a free-running divider counter per divider and a fixed-depth register pipeline per destination.

Top module: `trig_xbar`

## Requirements
- R1: While `rst_n` is low, every `dst_oe` and every `dst_out` bit is 0, and both divider exponents return to 1.
- R2: The source index field (route word bits [7:0]) selects as follows: 0 gives constant low, 1 gives constant high, 2 gives the software trigger, and 3+k gives `trig_in[k]`. Any index at or above `N_EXT+3` gives low.
- R3: Route word bit 8 is the enable. Bit 9 = 0 selects an asynchronous route, whose `dst_out` follows the selected source combinationally in the same cycle. A route word takes effect right after the clock edge that captures its write.
- R4: Route word bit 13 = 1 inverts the destination output, on both asynchronous and synchronous routes.
- R5: For a synchronous route sampling the rising edge (bit 9 = 1, bit 10 = 0, full rate), a source change is first visible on `dst_out` after the third rising edge that follows it.
- R6: For a synchronous route sampling the falling edge (bit 10 = 1, full rate), the change is visible after the falling edge that follows the second rising edge. This is half a cycle earlier than the rising-edge route.
- R7: Route word bits [12:11] select the clock rate: 0 or 3 is full rate, 1 is divider A, 2 is divider B. Divider A's exponent register is at address `N_DST` and divider B's is at address `N_DST+1`, each written from data bits [3:0]. An exponent of 0 is treated as 1, and an exponent above 9 is treated as 9. A divider with exponent e strobes once every 2^e cycles. Writing an exponent restarts that divider's count, so its first strobe comes in the cycle after 2^e-1 further rising edges. A synchronous route's output register loads only on its strobe.
- R8: With the enable bit at 0, the destination's `dst_oe` and `dst_out` are both 0, whatever the source.
- R9: A write to address `N_DST+2` makes the software trigger high for exactly the one cycle after the write edge.
- R10: A write to an address above `N_DST+2` changes no route and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synchronization clock and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Configuration write address |
| wr_data | input | 14 | Route word or divider exponent |
| trig_in | input | N_EXT | External trigger sources |
| dst_out | output | N_DST | Destination trigger levels |
| dst_oe | output | N_DST | Destination output enables |

## Verification
The bench builds the block with its defaults: eight external inputs, four destinations and a 4-bit address. With these values, every source class, the out-of-range index and the address just past the map can be reached. A divider exponent of 15 reaches the clamp at 512, so the longest strobe period is checked against an exact edge count. The divider tests write the exponent in the same cycle as the source change. Resetting the counter therefore gives the bench a known phase, and it can sample the single cycle in which the output must flip.

// File: rtl/trig_xbar_pkg.sv
package trig_xbar_pkg;

    localparam int SRC_FW  = 8;
    localparam int EXP_W   = 4;
    localparam int MAX_EXP = 9;

    typedef enum logic [1:0] {
        RATE_FULL = 2'd0,
        RATE_DIVA = 2'd1,
        RATE_DIVB = 2'd2,
        RATE_ALT  = 2'd3
    } rate_e;

    // packed from MSB: inv[13] rate[12:11] fall[10] sync[9] en[8] src[7:0]
    typedef struct packed {
        logic              inv;
        rate_e             rate;
        logic              fall;
        logic              sync;
        logic              en;
        logic [SRC_FW-1:0] src;
    } route_cfg_t;

    localparam int CFG_W = $bits(route_cfg_t);

endpackage

// File: rtl/trig_clkdiv.sv
module trig_clkdiv
    import trig_xbar_pkg::*;
#(
    parameter int MAXE = MAX_EXP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exp_wr,
    input  logic [EXP_W-1:0] exp_val,
    output logic             tick
);
    localparam int CNT_W = MAXE;

    logic [EXP_W-1:0] exp_q;
    logic [EXP_W-1:0] exp_clamped;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        if (exp_val == '0)
            exp_clamped = EXP_W'(1);
        else if (int'(exp_val) > MAXE)
            exp_clamped = EXP_W'(MAXE);
        else
            exp_clamped = exp_val;
    end

    always_comb mask = CNT_W'((32'd1 << exp_q) - 32'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= EXP_W'(1);
            cnt_q <= '0;
        end else if (exp_wr) begin
            exp_q <= exp_clamped;
            cnt_q <= '0;
        end else if (cnt_q == mask) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == mask);

    // R7: strobes never come back to back (exponent is at least 1)
    p_tick_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7: counter stays inside the current period
    p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= mask);

endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_xbar_pkg::*;
#(
    parameter int N_DST  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output route_cfg_t        cfg [N_DST],
    output logic              exp_wr_a,
    output logic              exp_wr_b,
    output logic [EXP_W-1:0]  exp_val,
    output logic              sw_pulse
);
    localparam logic [ADDR_W-1:0] A_DIVA = ADDR_W'(N_DST);
    localparam logic [ADDR_W-1:0] A_DIVB = ADDR_W'(N_DST + 1);
    localparam logic [ADDR_W-1:0] A_SWTR = ADDR_W'(N_DST + 2);

    for (genvar i = 0; i < N_DST; i++) begin : g_route
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg[i] <= '0;
            else if (wr_valid && wr_addr == ADDR_W'(i))
                cfg[i] <= route_cfg_t'(wr_data);
        end
    end

    assign exp_wr_a = wr_valid && (wr_addr == A_DIVA);
    assign exp_wr_b = wr_valid && (wr_addr == A_DIVB);
    assign exp_val  = wr_data[EXP_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sw_pulse <= 1'b0;
        else
            sw_pulse <= wr_valid && (wr_addr == A_SWTR);
    end

    // R9: a software trigger pulse only follows a write to its address
    p_sw_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pulse |-> $past(wr_valid && (wr_addr == A_SWTR)));

endmodule

// File: rtl/trig_route_lane.sv
module trig_route_lane
    import trig_xbar_pkg::*;
#(
    parameter int N_SRC = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  route_cfg_t       cfg,
    input  logic [N_SRC-1:0] src_vec,
    input  logic             tick_a,
    input  logic             tick_b,
    output logic             out,
    output logic             oe
);
    logic sel;
    logic s1_q, s2_q;
    logic rise_q, fall_q;
    logic tick;
    logic data;

    always_comb begin
        sel = 1'b0;
        for (int k = 0; k < N_SRC; k++)
            if (cfg.src == SRC_FW'(k)) sel = src_vec[k];
    end

    always_comb begin
        unique case (cfg.rate)
            RATE_DIVA: tick = tick_a;
            RATE_DIVB: tick = tick_b;
            RATE_FULL,
            RATE_ALT:  tick = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= sel;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rise_q <= 1'b0;
        else if (tick)
            rise_q <= s2_q;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            fall_q <= 1'b0;
        else if (tick)
            fall_q <= s2_q;
    end

    always_comb begin
        data = cfg.sync ? (cfg.fall ? fall_q : rise_q) : sel;
        out  = cfg.en & (data ^ cfg.inv);
        oe   = cfg.en;
    end

    // R7: the rising-edge output register holds between strobes
    p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(rise_q));

endmodule

// File: rtl/trig_xbar.sv
module trig_xbar
    import trig_xbar_pkg::*;
#(
    parameter int N_EXT  = 8,
    parameter int N_DST  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic [N_EXT-1:0]  trig_in,
    output logic [N_DST-1:0]  dst_out,
    output logic [N_DST-1:0]  dst_oe
);
    localparam int N_SRC = N_EXT + 3;

    route_cfg_t       cfg [N_DST];
    logic             exp_wr_a, exp_wr_b;
    logic [EXP_W-1:0] exp_val;
    logic             sw_pulse;
    logic             tick_a, tick_b;
    logic [N_SRC-1:0] src_vec;

    trig_cfg_regs #(.N_DST(N_DST), .ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .exp_wr_a (exp_wr_a),
        .exp_wr_b (exp_wr_b),
        .exp_val  (exp_val),
        .sw_pulse (sw_pulse)
    );

    trig_clkdiv u_div_a (
        .clk(clk), .rst_n(rst_n), .exp_wr(exp_wr_a), .exp_val(exp_val), .tick(tick_a)
    );

    trig_clkdiv u_div_b (
        .clk(clk), .rst_n(rst_n), .exp_wr(exp_wr_b), .exp_val(exp_val), .tick(tick_b)
    );

    assign src_vec = {trig_in, sw_pulse, 1'b1, 1'b0};

    for (genvar d = 0; d < N_DST; d++) begin : g_lane
        trig_route_lane #(.N_SRC(N_SRC)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg[d]),
            .src_vec (src_vec),
            .tick_a  (tick_a),
            .tick_b  (tick_b),
            .out     (dst_out[d]),
            .oe      (dst_oe[d])
        );
    end

    // R8: no enabled output ever drives high without its enable
    p_out_needs_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_out & ~dst_oe) == '0);

endmodule

// File: tb/trig_xbar_tb.sv
module trig_xbar_tb;
    localparam int PERIOD = 10;
    localparam int N_EXT  = 8;
    localparam int N_DST  = 4;
    localparam int ADDR_W = 4;

    // vector: [17] expected, [16:9] trig_in, [8] invert, [7:0] source index
    localparam int NV = 10;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 8'hFF, 1'b0, 8'd0},
        {1'b1, 8'hFF, 1'b1, 8'd0},
        {1'b1, 8'h00, 1'b0, 8'd1},
        {1'b1, 8'h01, 1'b0, 8'd3},
        {1'b1, 8'h80, 1'b0, 8'd10},
        {1'b0, 8'h7F, 1'b0, 8'd10},
        {1'b0, 8'h04, 1'b1, 8'd5},
        {1'b0, 8'hFF, 1'b0, 8'd200},
        {1'b1, 8'hFF, 1'b1, 8'd200},
        {1'b0, 8'hFF, 1'b0, 8'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [13:0]       wr_data = '0;
    logic [N_EXT-1:0]  trig_in = '0;
    logic [N_DST-1:0]  dst_out;
    logic [N_DST-1:0]  dst_oe;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    trig_xbar #(.N_EXT(N_EXT), .N_DST(N_DST), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in), .dst_out(dst_out), .dst_oe(dst_oe)
    );

    function automatic logic [13:0] word(input logic [7:0] src, input logic en,
        input logic sync, input logic fall, input logic [1:0] rate, input logic inv);
        return {inv, rate, fall, sync, en, src};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // returns 1 ns after the capturing edge
    task automatic wr(input int addr, input logic [13:0] data);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk("R1 oe in reset", 32'(dst_oe), 0);
        chk("R1 out in reset", 32'(dst_out), 0);
        rst_n = 1'b1;

        // table: async routing on destination 0
        for (int v = 0; v < NV; v++) begin
            trig_in = VEC[v][16:9];
            wr(0, word(VEC[v][7:0], 1'b1, 1'b0, 1'b0, 2'd0, VEC[v][8]));
            #2;
            chk("R2 R3 R4 async route", 32'(dst_out[0]), 32'(VEC[v][17]));
            chk("R3 enable", 32'(dst_oe[0]), 1);
        end

        // R3: same-cycle combinational follow
        wr(0, word(8'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0));
        trig_in = 8'h00; #1;
        chk("R3 follow low", 32'(dst_out[0]), 0);
        trig_in = 8'h01; #1;
        chk("R3 follow high", 32'(dst_out[0]), 1);

        // R10: address above map ignored
        wr(0, word(8'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0));
        wr(9, 14'd0);
        #2;
        chk("R10 ignored addr out", 32'(dst_out[0]), 1);
        chk("R10 ignored addr oe", 32'(dst_oe[0]), 1);

        // R8: disabled route
        wr(1, word(8'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1));
        #2;
        chk("R8 disabled oe", 32'(dst_oe[1]), 0);
        chk("R8 disabled out", 32'(dst_out[1]), 0);

        // R5 / R6: full-rate synchronous routes, rising on 0, falling on 1
        trig_in = 8'h00;
        wr(0, word(8'd3, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0));
        wr(1, word(8'd3, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0));
        repeat (4) @(posedge clk);
        #1 trig_in[0] = 1'b1;
        @(posedge clk);
        @(posedge clk); #3;
        chk("R5 rise before", 32'(dst_out[0]), 0);
        chk("R6 fall before", 32'(dst_out[1]), 0);
        #5;
        chk("R6 fall after negedge", 32'(dst_out[1]), 1);
        chk("R5 rise not yet", 32'(dst_out[0]), 0);
        @(posedge clk); #3;
        chk("R5 rise third edge", 32'(dst_out[0]), 1);

        // R4 on sync route
        wr(0, word(8'd3, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1));
        #2;
        chk("R4 sync invert", 32'(dst_out[0]), 0);

        // R7: divider A, exponent 2, counter restarted with the write
        wr(2, word(8'd4, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0));
        repeat (20) @(posedge clk);
        #1;
        wr_valid = 1'b1; wr_addr = ADDR_W'(N_DST); wr_data = 14'd2; trig_in[1] = 1'b1;
        @(posedge clk); #1;
        wr_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(posedge clk); #2;
        chk("R7 divA before strobe", 32'(dst_out[2]), 0);
        @(posedge clk); #2;
        chk("R7 divA on strobe", 32'(dst_out[2]), 1);

        // R7: divider B, exponent 15 clamped to 9 (512)
        wr(3, word(8'd5, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0));
        repeat (20) @(posedge clk);
        #1;
        wr_valid = 1'b1; wr_addr = ADDR_W'(N_DST + 1); wr_data = 14'd15; trig_in[2] = 1'b1;
        @(posedge clk); #1;
        wr_valid = 1'b0;
        repeat (510) @(posedge clk);
        @(posedge clk); #2;
        chk("R7 divB clamp before", 32'(dst_out[3]), 0);
        @(posedge clk); #2;
        chk("R7 divB clamp strobe", 32'(dst_out[3]), 1);

        // R9: software trigger through async route on destination 3
        wr(3, word(8'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0));
        #2;
        chk("R9 idle", 32'(dst_out[3]), 0);
        wr(N_DST + 2, 14'd0);
        #2;
        chk("R9 pulse high", 32'(dst_out[3]), 1);
        @(posedge clk); #2;
        chk("R9 pulse one cycle", 32'(dst_out[3]), 0);

        // R1: reset again clears routes
        #1 rst_n = 1'b0;
        #2;
        chk("R1 oe after reset", 32'(dst_oe), 0);
        chk("R1 out after reset", 32'(dst_out), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule